// File: doc/BRIEF.md
# Dual-Strobe Up/Down Modulo-16 Counter

This block is a presettable 4-bit binary counter that takes two count strobes, one that raises the count and one that lowers it. A count step happens when a strobe rises. The count wraps around modulo 16 in both directions. Two active-low outputs, carry and borrow, follow the low phase of the matching strobe while the count sits at its top or bottom value. When the count wraps, that output rises, so it can drive the matching strobe of a following stage directly. Chaining stages this way builds wider counters with no extra logic.

The whole block runs on one system clock. Both strobes are sampled as ordinary synchronous levels, and their rising edges are found internally. An active-high clear forces the count to zero and wins over everything else. An active-low load copies a 4-bit data word into the count, whatever the strobes are doing. The strobe history keeps updating while clear or load is asserted. A strobe that is held low through an override therefore still counts when it next rises.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on upStb, with no rising edge on dnStb in the same cycle and with clear and load inactive, raises count by one, and 15 wraps to 0. The new value shows on the clock edge at which upStb is first sampled high.
- R2: A rising edge on dnStb, with no rising edge on upStb in the same cycle and with clear and load inactive, lowers count by one, and 0 wraps to 15. The timing is the same as in R1.
- R3: If both strobes rise in the same cycle, count does not change.
- R4: While masterClr is 1, count becomes 0 at the next clock edge. This holds whatever loadN, dataIn and the strobes are.
- R5: While loadN is 0 and masterClr is 0, count takes dataIn at the next clock edge. This holds whatever the strobes are.
- R6: carryN is 0 exactly when count is 15 and upStb was sampled 0 at the last clock edge. Otherwise carryN is 1.
- R7: borrowN is 0 exactly when count is 0 and dnStb was sampled 0 at the last clock edge. Otherwise borrowN is 1.
- R8: If a strobe is held 0 through a clear or a load and is still 0 after the override is released, its next rise counts.
- R9: A strobe that stays at a steady level, high or low, does not change count.
- R10: When stage A's carryN drives stage B's upStb and stage A's borrowN drives stage B's dnStb, the pair counts as an 8-bit counter. Stage B moves one clock after stage A wraps, so the pair goes from 255 to 0 and from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| masterClr | input | 1 | Clear, active high, highest priority |
| loadN | input | 1 | Parallel load, active low |
| dataIn | input | 4 | Value to load |
| upStb | input | 1 | Count-up strobe; counts on its rising edge |
| dnStb | input | 1 | Count-down strobe; counts on its rising edge |
| count | output | 4 | Current count |
| carryN | output | 1 | Active-low terminal count at 15, follows the low phase of upStb |
| borrowN | output | 1 | Active-low terminal count at 0, follows the low phase of dnStb |

## Verification
A strobe rise, a clear or a load changes count at the first clock edge that samples it. carryN and borrowN settle at that same edge, because they decode the registered count and the registered strobe level. In a chained pair, the upper stage moves one edge later than the wrap of the lower stage. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares every output, on both stages, with a cycle-accurate reference model. That model feeds the lower stage's previous expected carry and borrow to the upper stage, so the one-cycle cascade lag is checked exactly and not merely waited out.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Per-cycle commands from the control half to the count register.
  typedef struct packed {
    logic clear;
    logic load;
    logic incr;
    logic decr;
  } cntCmd_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic    clk,
  input  logic    masterClr,
  input  logic    loadN,
  input  logic    upStb,
  input  logic    dnStb,
  output cntCmd_t cmd,
  output logic    upLvl,
  output logic    dnLvl
);
  localparam int NSTB = 2;

  logic [NSTB-1:0] stbNow;
  logic [NSTB-1:0] stbLast;
  logic [NSTB-1:0] stbRise;

  assign stbNow = {dnStb, upStb};

  // Sampling runs without any override, so the history stays live
  // through clear and load.
  for (genvar i = 0; i < NSTB; i++) begin : g_edge
    logic lastQ;
    always_ff @(posedge clk) lastQ <= stbNow[i];
    assign stbLast[i] = lastQ;
    assign stbRise[i] = stbNow[i] & ~lastQ;
  end

  always_comb begin
    cmd.clear = masterClr;
    cmd.load  = ~masterClr & ~loadN;
    cmd.incr  = stbRise[0] & ~stbRise[1];
    cmd.decr  = stbRise[1] & ~stbRise[0];
  end

  assign upLvl = stbLast[0];
  assign dnLvl = stbLast[1];
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  cntCmd_t          cmd,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             upLvl,
  input  logic             dnLvl,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOPV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONEV = WIDTH'(1);

  logic [WIDTH-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (cmd.clear)     cntQ <= '0;
    else if (cmd.load) cntQ <= dataIn;
    else if (cmd.incr) cntQ <= cntQ + ONEV;
    else if (cmd.decr) cntQ <= cntQ - ONEV;
  end

  assign count   = cntQ;
  assign carryN  = ~((cntQ == TOPV) & ~upLvl);
  assign borrowN = ~((cntQ == '0) & ~dnLvl);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             masterClr,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             upStb,
  input  logic             dnStb,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  cntCmd_t cmd;
  logic    upLvl;
  logic    dnLvl;

  updn_ctrl u_ctrl (
    .clk      (clk),
    .masterClr(masterClr),
    .loadN    (loadN),
    .upStb    (upStb),
    .dnStb    (dnStb),
    .cmd      (cmd),
    .upLvl    (upLvl),
    .dnLvl    (dnLvl)
  );

  updn_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .cmd    (cmd),
    .dataIn (dataIn),
    .upLvl  (upLvl),
    .dnLvl  (dnLvl),
    .count  (count),
    .carryN (carryN),
    .borrowN(borrowN)
  );
endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             masterClr,
  input logic             loadN,
  input logic [WIDTH-1:0] dataIn,
  input logic             upStb,
  input logic             dnStb,
  input logic [WIDTH-1:0] count,
  input logic             carryN,
  input logic             borrowN
);
  localparam logic [WIDTH-1:0] TOPV = {WIDTH{1'b1}};

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_up_step_r1: assert property (@(posedge clk) disable iff (masterClr || !armed)
    (loadN && upStb && !$past(upStb) && !(dnStb && !$past(dnStb)))
      |=> count == WIDTH'($past(count) + 1'b1));

  p_dn_step_r2: assert property (@(posedge clk) disable iff (masterClr || !armed)
    (loadN && dnStb && !$past(dnStb) && !(upStb && !$past(upStb)))
      |=> count == WIDTH'($past(count) - 1'b1));

  p_both_rise_r3: assert property (@(posedge clk) disable iff (masterClr || !armed)
    (loadN && upStb && !$past(upStb) && dnStb && !$past(dnStb)) |=> $stable(count));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!armed)
    masterClr |=> count == '0);

  p_load_copy_r5: assert property (@(posedge clk) disable iff (!armed)
    (!masterClr && !loadN) |=> count == $past(dataIn));

  p_carry_r6: assert property (@(posedge clk) disable iff (!armed)
    carryN == !(count == TOPV && !$past(upStb)));

  p_borrow_r7: assert property (@(posedge clk) disable iff (!armed)
    borrowN == !(count == '0 && !$past(dnStb)));

  p_steady_r9: assert property (@(posedge clk) disable iff (masterClr || !armed)
    (loadN && !(upStb && !$past(upStb)) && !(dnStb && !$past(dnStb))) |=> $stable(count));
endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .masterClr(masterClr),
  .loadN    (loadN),
  .dataIn   (dataIn),
  .upStb    (upStb),
  .dnStb    (dnStb),
  .count    (count),
  .carryN   (carryN),
  .borrowN  (borrowN)
);

// File: tb/dual_strobe_counter_tb.sv
module dual_strobe_counter_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       tClr = 1'b1, tLdN = 1'b1, tUp = 1'b1, tDn = 1'b1;
  logic [3:0] tDlo = '0, tDhi = '0;
  logic [3:0] loCnt, hiCnt;
  logic       loCarryN, loBorrowN, hiCarryN, hiBorrowN;

  int nChecks = 0;
  int nFails  = 0;

  dual_strobe_counter u_dut (
    .clk(clk), .masterClr(tClr), .loadN(tLdN), .dataIn(tDlo),
    .upStb(tUp), .dnStb(tDn),
    .count(loCnt), .carryN(loCarryN), .borrowN(loBorrowN)
  );

  // R10: upper stage strobed by the lower stage's terminal counts.
  dual_strobe_counter u_hi (
    .clk(clk), .masterClr(tClr), .loadN(tLdN), .dataIn(tDhi),
    .upStb(loCarryN), .dnStb(loBorrowN),
    .count(hiCnt), .carryN(hiCarryN), .borrowN(hiBorrowN)
  );

  // Reference model state.
  logic [3:0] mLo = '0, mHi = '0;
  logic mUpQ = 1'b1, mDnQ = 1'b1, mHiUpQ = 1'b1, mHiDnQ = 1'b1;
  logic mCarry = 1'b1, mBorrow = 1'b1;

  function automatic logic [3:0] nextCnt(logic [3:0] c, logic upQ, logic dnQ,
      logic up, logic dn, logic clr, logic ldN, logic [3:0] d);
    logic ur, dr;
    ur = up & ~upQ;
    dr = dn & ~dnQ;
    if (clr)            return 4'd0;
    else if (!ldN)      return d;
    else if (ur && !dr) return c + 4'd1;
    else if (dr && !ur) return c - 4'd1;
    else                return c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic up, logic dn, logic clr, logic ldN,
                     logic [3:0] dlo, logic [3:0] dhi, string tag);
    logic [3:0] nLo, nHi;
    tUp = up; tDn = dn; tClr = clr; tLdN = ldN; tDlo = dlo; tDhi = dhi;
    @(posedge clk);
    nLo = nextCnt(mLo, mUpQ, mDnQ, up, dn, clr, ldN, dlo);
    nHi = nextCnt(mHi, mHiUpQ, mHiDnQ, mCarry, mBorrow, clr, ldN, dhi);
    mHiUpQ = mCarry; mHiDnQ = mBorrow;
    mUpQ = up; mDnQ = dn;
    mLo = nLo; mHi = nHi;
    mCarry  = !(mLo == 4'd15 && !mUpQ);
    mBorrow = !(mLo == 4'd0 && !mDnQ);
    @(negedge clk);
    check(tag, "count", loCnt, mLo);
    check(tag, "carryN (R6)", loCarryN, mCarry);
    check(tag, "borrowN (R7)", loBorrowN, mBorrow);
    check(tag, "8-bit value (R10)", {hiCnt, loCnt}, {mHi, mLo});
  endtask

  task automatic upPulse(string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, tag);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, tag);
  endtask

  task automatic dnPulse(string tag);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, tag);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, tag);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd5150));
    // R4: clear with load and strobes active.
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd9, 4'd3, "R4 reset");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R4 release");
    // R5: load while both strobes toggle.
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'd14, 4'd2, "R5 load");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'd14, 4'd2, "R5 load strobes rise");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R5 hold");
    // R1 + R6: step to 15, carry low while upStb low, wrap into the upper stage.
    upPulse("R1 14->15");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R6 carry low at 15");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R6 carry held low");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R1 wrap 15->0");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R10 upper stage step");
    // R2 + R7: borrow at 0, wrap down.
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, "R7 borrow low at 0");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R2 wrap 0->15");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R10 upper stage back");
    // R3: simultaneous rise.
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, "R3 both low");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R3 both rise");
    // R9: steady levels.
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R9 steady high");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R9 steady low");
    // R8: up held low through clear, then load.
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R8 clear up low");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R8 released");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R8 first rise counts");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 4'd0, "R8 load dn low");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, "R8 released");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R8 first rise counts");
    // R10: full 8-bit wrap 255->0 and 0->255.
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 4'd15, "R10 load 255");
    upPulse("R10 255->0");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R10 settle 0");
    dnPulse("R10 0->255");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R10 settle 255");
    // Random mix with R1/R2 pulses, loads, clears and double rises.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 32);
      if (r == 0)
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R4 random clear");
      else if (r < 3)
        cyc(1'($urandom), 1'($urandom), 1'b0, 1'b0, 4'($urandom), 4'($urandom), "R5 random load");
      else if (r == 3) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0, "R3 random both");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, "R3 random both");
      end
      else if (r < 18) upPulse("R1 random up");
      else dnPulse("R2 random down");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule